// File: doc/BRIEF.md
# Mixed-Width Unsigned Magnitude Comparator

This block compares two unsigned operands and returns one bit telling whether a chosen relation holds between them. The two operands may have different widths. Before comparison, both are widened to the larger of the two widths, with the missing upper bits read as zero. A compile-time parameter selects the relation: strictly less, less or equal, strictly greater, or greater or equal. The block has no clock and no reset, so the result follows the operands within the same cycle.

The comparison walks from the top bit position down to bit 0. At each position it keeps a term that is true while every bit above that position matches. It also forms one decision term, which fires at the highest position where the operands differ in the direction the relation favours. All decision terms are OR-combined into the result. For the two non-strict relations, the "all bits match" term joins that OR as one more input.

An integrator places one instance wherever a threshold or ordering test is needed. Width parameters of 0 and relation codes outside the four listed are refused when the design is elaborated.

Top module: `cmp_mag_top`

## Requirements
- R1: With `A_W` different from `B_W`, the compare runs at `max(A_W, B_W)` bits. Every bit above an operand's own width counts as 0, so the result equals the relation applied to both operands zero-extended.
- R2: With `REL` = 0 (less-than), `hit` is 1 exactly when `a < b`.
- R3: With `REL` = 1 (less-or-equal), `hit` is 1 exactly when `a <= b`.
- R4: With `REL` = 2 (greater-than), `hit` is 1 exactly when `a > b`.
- R5: With `REL` = 3 (greater-or-equal), `hit` is 1 exactly when `a >= b`.
- R6: When the zero-extended operands are equal, `hit` is 0 for codes 0 and 2 and 1 for codes 1 and 3. No per-bit decision term fires in that case.
- R7: `hit` is purely combinational. A change on `a` or `b` shows on `hit` within the same clock period, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | A_W | First unsigned operand |
| b | input | B_W | Second unsigned operand |
| hit | output | 1 | 1 when the relation selected by `REL` holds for `a` and `b` |

## Verification
In the non-strict relations, the equality term and a per-bit decision term both feed the same OR. The case that matters is when neither should fire, or only one should. Operand pairs that match everywhere, or that differ only at bit 0, are applied to all four relations side by side. The output is compared against the language's native relational operator on zero-extended values. The sweep covers every pair at widths 8/8, 8/4 and 4/8, plus seeded random pairs at 16/12. That shows whether the equality input and a decision term can ever wrongly raise, or fail to raise, the result together.

// File: rtl/cmp_mag_pkg.sv
package cmp_mag_pkg;
    localparam int REL_LT  = 0;
    localparam int REL_LTE = 1;
    localparam int REL_GT  = 2;
    localparam int REL_GTE = 3;

    function automatic bit rel_valid(int rel);
        return (rel >= REL_LT) && (rel <= REL_GTE);
    endfunction

    // true for the relations that also accept equal operands
    function automatic bit rel_inclusive(int rel);
        return (rel == REL_LTE) || (rel == REL_GTE);
    endfunction

    // true when the relation favours the first operand being larger
    function automatic bit rel_a_side(int rel);
        return (rel == REL_GT) || (rel == REL_GTE);
    endfunction
endpackage

// File: rtl/cmp_mag_zext.sv
module cmp_mag_zext #(
    parameter int IN_W  = 4,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  d,
    output logic [OUT_W-1:0] q
);
    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < IN_W) begin : g_pass
            assign q[i] = d[i];
        end else begin : g_zero
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/cmp_mag_chain.sv
module cmp_mag_chain #(
    parameter int W      = 8,
    parameter bit A_SIDE = 1'b0
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic [W-1:0] term,
    output logic         same_all
);
    // same_above[k] is high while every bit at position >= k matches
    logic [W:0] same_above;
    assign same_above[W] = 1'b1;

    for (genvar i = W - 1; i >= 0; i--) begin : g_pos
        logic wins_here;
        if (A_SIDE) begin : g_agt
            assign wins_here = opa[i] & ~opb[i];
        end else begin : g_blt
            assign wins_here = ~opa[i] & opb[i];
        end
        assign term[i]       = wins_here & same_above[i+1];
        assign same_above[i] = same_above[i+1] & ~(opa[i] ^ opb[i]);
    end

    assign same_all = same_above[0];
endmodule

// File: rtl/cmp_mag_orred.sv
module cmp_mag_orred #(
    parameter int N = 8
) (
    input  logic [N-1:0] din,
    output logic         any
);
    assign any = |din;
endmodule

// File: rtl/cmp_mag_top.sv
module cmp_mag_top
    import cmp_mag_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 8,
    parameter int REL = REL_LT
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           hit
);
    localparam int  CW     = (A_W > B_W) ? A_W : B_W;
    localparam bit  INCL   = rel_inclusive(REL);
    localparam bit  A_SIDE = rel_a_side(REL);
    localparam int  RED_N  = CW + (INCL ? 1 : 0);

    if (!rel_valid(REL)) begin : g_bad_rel
        $error("cmp_mag_top: relation code %0d is not supported", REL);
    end
    if (A_W < 1 || B_W < 1) begin : g_bad_w
        $error("cmp_mag_top: operand widths must be at least 1");
    end

    logic [CW-1:0]    ax, bx, term;
    logic             same_all;
    logic [RED_N-1:0] red_in;

    cmp_mag_zext #(.IN_W(A_W), .OUT_W(CW)) u_zext_a (.d(a), .q(ax));
    cmp_mag_zext #(.IN_W(B_W), .OUT_W(CW)) u_zext_b (.d(b), .q(bx));

    cmp_mag_chain #(.W(CW), .A_SIDE(A_SIDE)) u_chain (
        .opa      (ax),
        .opb      (bx),
        .term     (term),
        .same_all (same_all)
    );

    if (INCL) begin : g_incl
        assign red_in = {same_all, term};
    end else begin : g_strict
        assign red_in = term;
    end

    cmp_mag_orred #(.N(RED_N)) u_red (.din(red_in), .any(hit));

    always_comb begin
        // R6
        eq_detect_chk: assert ((ax != bx) || same_all);
        // R6
        eq_quiet_chk: assert (!same_all || (term == '0));
        // R2
        single_term_chk: assert ($onehot0(term));
        // R6
        incl_eq_hit_chk: assert (!(INCL && same_all) || hit);
        // R4
        strict_neq_chk: assert (INCL || !hit || (ax != bx));
    end
endmodule

// File: tb/cmp_mag_top_tb_top.sv
module cmp_mag_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [7:0]  a8 = '0, b8 = '0;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [15:0] a16 = '0;
    logic [11:0] b12 = '0;
    logic [3:0]  h88, h84, h48, h1612;

    for (genvar r = 0; r < 4; r++) begin : g88
        cmp_mag_top #(.A_W(8), .B_W(8), .REL(r)) dut_i (.a(a8), .b(b8), .hit(h88[r]));
    end
    for (genvar r = 0; r < 4; r++) begin : g84
        cmp_mag_top #(.A_W(8), .B_W(4), .REL(r)) dut_i (.a(a8), .b(b4), .hit(h84[r]));
    end
    for (genvar r = 0; r < 4; r++) begin : g48
        cmp_mag_top #(.A_W(4), .B_W(8), .REL(r)) dut_i (.a(a4), .b(b8), .hit(h48[r]));
    end
    for (genvar r = 0; r < 4; r++) begin : g1612
        cmp_mag_top #(.A_W(16), .B_W(12), .REL(r)) dut_i (.a(a16), .b(b12), .hit(h1612[r]));
    end

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    function automatic logic ref_rel(int r, logic [15:0] x, logic [15:0] y);
        case (r)
            0: return x <  y;
            1: return x <= y;
            2: return x >  y;
            default: return x >= y;
        endcase
    endfunction

    function automatic string rel_tag(int r);
        case (r)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check_set(string pre, logic [3:0] got, logic [15:0] x, logic [15:0] y);
        for (int r = 0; r < 4; r++) begin
            logic  exp;
            string req;
            exp = ref_rel(r, x, y);
            req = (x == y) ? {pre, "R6"} : {pre, rel_tag(r)};
            n_cmp++;
            if (got[r] !== exp) begin
                n_bad++;
                $display("FAIL %s rel=%0d a=%0d b=%0d actual=%b expected=%b",
                         req, r, x, y, got[r], exp);
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        // all-zero start: equal operands everywhere (R6)
        #1;
        check_set("", h88, 16'(a8), 16'(b8));
        check_set("R1/", h84, 16'(a8), 16'(b4));
        check_set("R1/", h48, 16'(a4), 16'(b8));
        check_set("R1/", h1612, a16, 16'(b12));

        // R7: change inputs mid-period, sample before the next edge
        @(posedge clk);
        #1 a8 = 8'd7; b8 = 8'd9;
        #1 check_set("R7/", h88, 16'(a8), 16'(b8));
        #1 a8 = 8'd9;
        #1 check_set("R7/", h88, 16'(a8), 16'(b8));

        // directed corners: extreme values, differences only in bit 0 or in the top bit
        a8 = 8'hFF; b4 = 4'hF; a4 = 4'hF; b8 = 8'hFF; a16 = 16'h0FFF; b12 = 12'hFFF;
        #1;
        check_set("R1/", h84, 16'(a8), 16'(b4));
        check_set("R1/", h48, 16'(a4), 16'(b8));
        check_set("R1/", h1612, a16, 16'(b12));
        a8 = 8'h0F; a16 = 16'h8000; b12 = 12'h000;
        #1;
        check_set("R1/", h84, 16'(a8), 16'(b4));
        check_set("R1/", h1612, a16, 16'(b12));

        // R1..R6: every pair at equal widths 8/8
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 256; j++) begin
                a8 = 8'(i); b8 = 8'(j);
                #1 check_set("", h88, 16'(a8), 16'(b8));
            end
        end

        // R1: every pair in both width orderings 8/4 and 4/8
        for (int i = 0; i < 256; i++) begin
            for (int j = 0; j < 16; j++) begin
                a8 = 8'(i); b4 = 4'(j); a4 = 4'(j); b8 = 8'(i);
                #1;
                check_set("R1/", h84, 16'(a8), 16'(b4));
                check_set("R1/", h48, 16'(a4), 16'(b8));
            end
        end

        // R1: seeded random pairs at 16/12, biased toward near-equal values
        void'($urandom(32'd20240611));
        for (int k = 0; k < 20000; k++) begin
            a16 = 16'($urandom);
            if (k % 3 == 0) b12 = a16[11:0] ^ 12'($urandom_range(0, 1));
            else            b12 = 12'($urandom);
            if (k % 5 == 0) a16[15:12] = 4'h0;
            #1 check_set("R1/", h1612, a16, 16'(b12));
        end

        finish_run();
    end
endmodule